// File: doc/BRIEF.md
# FIFO Level Request Generator

This block sits between an audio serial port and the system side of a chip. It holds a transmit FIFO, which the system fills and the serializer drains, and a receive FIFO, which the deserializer fills and the system drains. Each FIFO keeps its own fill level. Six programmable thresholds are compared against the two levels. From those comparisons the block drives two DMA request lines and one interrupt line. Each of the six comparison sources has its own enable.

The pairing is fixed. Each output line combines one transmit source and one receive source. A transmit comparison becomes true once its FIFO has drained down to its threshold. A receive comparison becomes true once its FIFO has filled up to its threshold.

A small register interface writes the thresholds and the enables. The same interface reads back a status word. That word holds the three request conditions before enable masking, plus both current FIFO levels.

All four data ports use valid/ready. A beat moves on a clock edge where valid and ready are both high. The block lowers `tx_in_ready` / `rx_in_ready` while its FIFO is full. It lowers `tx_out_valid` / `rx_out_valid` while its FIFO is empty. The output data always shows the oldest entry. A producer may hold valid high for any length of time, and nothing is lost while ready is low.

Top module: `fifo_level_req_gen`

## Requirements
- R1: Each FIFO holds 8 entries. It returns them in the order they were written. Its level output counts from 0 to 8.
- R2: An accepted write alone raises the level by one. An accepted read alone lowers it by one. An accepted write and read on the same edge leave the level unchanged.
- R3: A write offered while the FIFO is full is refused, because input ready is low. A read attempted while the FIFO is empty is refused, because output valid is low. In both cases the level and the contents are unchanged.
- R4: A transmit comparison (sources tx_dma1, tx_dma2, tx_irq) is true when its threshold is greater than or equal to the transmit level.
- R5: A receive comparison (sources rx_dma1, rx_dma2, rx_irq) is true when its threshold is less than or equal to the receive level.
- R6: `irq` is (tx_irq comparison AND its enable) OR (rx_irq comparison AND its enable).
- R7: `dma_req[0]` is formed from the tx_dma1 and rx_dma1 sources. `dma_req[1]` is formed from the tx_dma2 and rx_dma2 sources. In each case a source contributes only when its comparison is true and its enable is set.
- R8: The status word is read at address 7. Bit 0 is the tx_irq comparison OR the rx_irq comparison. Bit 1 is the OR of both dma1 comparisons. Bit 2 is the OR of both dma2 comparisons. All three bits ignore the enables. Bits [7:4] hold the transmit level and bits [11:8] hold the receive level.
- R9: The request and status bits are registered. They change one clock after the level, threshold or enable change that causes them.
- R10: Reset empties both FIFOs and sets every threshold and every enable to 0. It also drives `irq` and `dma_req` low.
- R11: The register map is as follows. Addresses 0 to 5 hold the 4-bit thresholds for tx_dma1, rx_dma1, tx_dma2, rx_dma2, tx_irq and rx_irq, in that order. Address 6 holds the enables in bits [5:0], in the same order. Reads return the stored values. Writes to address 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_in_valid | input | 1 | System offers a transmit word |
| tx_in_ready | output | 1 | Transmit FIFO not full |
| tx_in_data | input | 16 | Transmit word from the system |
| tx_out_valid | output | 1 | Transmit FIFO not empty |
| tx_out_ready | input | 1 | Serializer takes the head word |
| tx_out_data | output | 16 | Oldest transmit word |
| rx_in_valid | input | 1 | Deserializer offers a received word |
| rx_in_ready | output | 1 | Receive FIFO not full |
| rx_in_data | input | 16 | Received word |
| rx_out_valid | output | 1 | Receive FIFO not empty |
| rx_out_ready | input | 1 | System takes the head word |
| rx_out_data | output | 16 | Oldest received word |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| tx_level | output | 4 | Transmit FIFO fill level |
| rx_level | output | 4 | Receive FIFO fill level |
| irq | output | 1 | Masked interrupt request |
| dma_req | output | 2 | Masked DMA request lines |

## Verification
A level counter that drifts becomes visible in two places. It shows on the level ports at the next edge. It also shows in the request lines one edge after that, once a threshold sits at the drifted value. A wrong head pointer shows up at once as out-of-order data on the output ports. A swapped comparison sense, or a wrong source-to-line pairing, flips a request or status bit one clock after the level crosses the threshold. The bench therefore places thresholds exactly at the levels it drives and samples both before and after that registered clock.

// File: rtl/lvlreq_pkg.sv
package lvlreq_pkg;
  // comparison sources; even index = transmit side, odd index = receive side
  localparam int SRC_N       = 6;
  localparam int SRC_TX_DMA1 = 0;
  localparam int SRC_RX_DMA1 = 1;
  localparam int SRC_TX_DMA2 = 2;
  localparam int SRC_RX_DMA2 = 3;
  localparam int SRC_TX_IRQ  = 4;
  localparam int SRC_RX_IRQ  = 5;
  localparam int LINE_N      = SRC_N / 2;  // dma0, dma1, irq

  // register addresses
  localparam logic [2:0] ADDR_ENABLE = 3'd6;
  localparam logic [2:0] ADDR_STATUS = 3'd7;

  // status word field positions
  localparam int ST_IRQ   = 0;
  localparam int ST_DMA1  = 1;
  localparam int ST_DMA2  = 2;
  localparam int ST_TXLVL = 4;
  localparam int ST_RXLVL = 8;
endpackage

// File: rtl/lvlreq_fifo.sv
module lvlreq_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [LVL_W-1:0]  level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LVL_W-1:0]  level_q;
  logic              push, pop;

  assign in_ready  = (level_q != LVL_FULL);
  assign out_valid = (level_q != '0);
  assign push      = in_valid & in_ready;
  assign pop       = out_valid & out_ready;
  assign out_data  = mem[rd_ptr];
  assign level     = level_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      unique case ({push, pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end
endmodule

// File: rtl/lvlreq_regs.sv
module lvlreq_regs
  import lvlreq_pkg::*;
#(
  parameter int THR_W  = 4,
  parameter int REG_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [REG_W-1:0]            wdata,
  input  logic [REG_W-1:0]            status_word,
  output logic [SRC_N-1:0][THR_W-1:0] thr,
  output logic [SRC_N-1:0]            en,
  output logic [REG_W-1:0]            rdata
);
  logic [SRC_N-1:0][THR_W-1:0] thr_q;
  logic [SRC_N-1:0]            en_q;

  generate
    for (genvar i = 0; i < SRC_N; i++) begin : g_thr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             thr_q[i] <= '0;
        else if (wr && addr == ADDR_W'(i))      thr_q[i] <= wdata[THR_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      en_q <= '0;
    else if (wr && addr == ADDR_W'(ADDR_ENABLE))     en_q <= wdata[SRC_N-1:0];
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADDR_STATUS))      rdata = status_word;
    else if (addr == ADDR_W'(ADDR_ENABLE)) rdata = REG_W'(en_q);
    else if (int'(addr) < SRC_N)           rdata = REG_W'(thr_q[addr]);
  end

  assign thr = thr_q;
  assign en  = en_q;
endmodule

// File: rtl/lvlreq_cmp.sv
module lvlreq_cmp
  import lvlreq_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SRC_N-1:0][LVL_W-1:0] thr,
  input  logic [SRC_N-1:0]            en,
  input  logic [LVL_W-1:0]            tx_level,
  input  logic [LVL_W-1:0]            rx_level,
  output logic [LINE_N-1:0]           line_masked,  // [0]=dma0 [1]=dma1 [2]=irq
  output logic [LINE_N-1:0]           line_raw
);
  logic [SRC_N-1:0]  hit;
  logic [LINE_N-1:0] masked_d, raw_d;

  generate
    for (genvar i = 0; i < SRC_N; i++) begin : g_src
      if (i % 2 == 0) begin : g_tx
        assign hit[i] = (thr[i] >= tx_level);   // drained down to threshold
      end else begin : g_rx
        assign hit[i] = (thr[i] <= rx_level);   // filled up to threshold
      end
    end
    for (genvar k = 0; k < LINE_N; k++) begin : g_line
      assign masked_d[k] = (hit[2*k] & en[2*k]) | (hit[2*k+1] & en[2*k+1]);
      assign raw_d[k]    = hit[2*k] | hit[2*k+1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_masked <= '0;
      line_raw    <= '0;
    end else begin
      line_masked <= masked_d;
      line_raw    <= raw_d;
    end
  end
endmodule

// File: rtl/fifo_level_req_gen.sv
module fifo_level_req_gen
  import lvlreq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int REG_W  = 16,
  parameter int ADDR_W = 3,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [DATA_W-1:0] tx_in_data,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [DATA_W-1:0] tx_out_data,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [DATA_W-1:0] rx_out_data,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [LVL_W-1:0]  tx_level,
  output logic [LVL_W-1:0]  rx_level,
  output logic              irq,
  output logic [1:0]        dma_req
);
  logic [SRC_N-1:0][LVL_W-1:0] thr_q;
  logic [SRC_N-1:0]            en_q;
  logic [LINE_N-1:0]           line_masked, line_raw;
  logic [REG_W-1:0]            status_word;

  lvlreq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .level(tx_level)
  );

  lvlreq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .level(rx_level)
  );

  lvlreq_regs #(.THR_W(LVL_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .status_word(status_word),
    .thr(thr_q), .en(en_q), .rdata(reg_rdata)
  );

  lvlreq_cmp #(.LVL_W(LVL_W)) cmp_i (
    .clk(clk), .rst_n(rst_n),
    .thr(thr_q), .en(en_q),
    .tx_level(tx_level), .rx_level(rx_level),
    .line_masked(line_masked), .line_raw(line_raw)
  );

  always_comb begin
    status_word = '0;
    status_word[ST_IRQ]  = line_raw[2];
    status_word[ST_DMA1] = line_raw[0];
    status_word[ST_DMA2] = line_raw[1];
    status_word[ST_TXLVL +: LVL_W] = tx_level;
    status_word[ST_RXLVL +: LVL_W] = rx_level;
  end

  assign dma_req = line_masked[1:0];
  assign irq     = line_masked[2];
endmodule

// File: rtl/lvlreq_chk.sv
module lvlreq_chk
  import lvlreq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 16,
  parameter int LVL_W  = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tx_in_valid,
  input logic                        tx_in_ready,
  input logic                        tx_out_valid,
  input logic                        tx_out_ready,
  input logic [LVL_W-1:0]            tx_level,
  input logic [LVL_W-1:0]            rx_level,
  input logic [SRC_N-1:0][LVL_W-1:0] thr_q,
  input logic [SRC_N-1:0]            en_q,
  input logic [REG_W-1:0]            status_word,
  input logic                        irq,
  input logic [1:0]                  dma_req
);
  logic tx_push, tx_pop;
  assign tx_push = tx_in_valid & tx_in_ready;
  assign tx_pop  = tx_out_valid & tx_out_ready;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_level) <= DEPTH) && (int'(rx_level) <= DEPTH)); // R1

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && !tx_pop) |=> (tx_level == $past(tx_level) + 1'b1)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_level) == DEPTH) |-> !tx_in_ready); // R3

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(((thr_q[SRC_TX_IRQ] >= tx_level) && en_q[SRC_TX_IRQ]) ||
                           ((thr_q[SRC_RX_IRQ] <= rx_level) && en_q[SRC_RX_IRQ])))); // R6

  AST_DMA0_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dma_req[0] == $past(((thr_q[SRC_TX_DMA1] >= tx_level) && en_q[SRC_TX_DMA1]) ||
                                  ((thr_q[SRC_RX_DMA1] <= rx_level) && en_q[SRC_RX_DMA1])))); // R7

  AST_STATUS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_word[ST_DMA2] == $past((thr_q[SRC_TX_DMA2] >= tx_level) ||
                                            (thr_q[SRC_RX_DMA2] <= rx_level)))); // R8

  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> (!irq && dma_req == 2'b00)); // R9
endmodule

bind fifo_level_req_gen lvlreq_chk #(.DEPTH(DEPTH), .REG_W(REG_W), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
  .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
  .tx_level(tx_level), .rx_level(rx_level),
  .thr_q(thr_q), .en_q(en_q), .status_word(status_word),
  .irq(irq), .dma_req(dma_req)
);

// File: tb/fifo_level_req_gen_tb_top.sv
module fifo_level_req_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_in_valid = 0, tx_out_ready = 0, rx_in_valid = 0, rx_out_ready = 0;
  logic [15:0] tx_in_data = '0, rx_in_data = '0;
  logic        tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [15:0] tx_out_data, rx_out_data;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [3:0]  tx_level, rx_level;
  logic        irq;
  logic [1:0]  dma_req;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fifo_level_req_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_level(tx_level), .rx_level(rx_level), .irq(irq), .dma_req(dma_req)
  );

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic push_tx(logic [15:0] d);
    tx_in_valid = 1; tx_in_data = d; tick(); tx_in_valid = 0;
  endtask
  task automatic pop_tx(); tx_out_ready = 1; tick(); tx_out_ready = 0; endtask
  task automatic push_rx(logic [15:0] d);
    rx_in_valid = 1; rx_in_data = d; tick(); rx_in_valid = 0;
  endtask
  task automatic pop_rx(); rx_out_ready = 1; tick(); rx_out_ready = 0; endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R10 irq", irq, 0);
    check("R10 dma_req", dma_req, 0);
    check("R10 tx_level", tx_level, 0);
    check("R10 rx_level", rx_level, 0);
    rd_reg(3'd0, d); check("R10 threshold", d, 0);
    rd_reg(3'd6, d); check("R10 enable", d, 0);
    tick(); tick();
    rd_reg(3'd7, d);  // thresholds 0, levels 0: every comparison true
    check("R8 status after reset", d, 16'h0007);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    for (int i = 0; i < 6; i++) wr_reg(3'(i), 16'(i + 1));
    for (int i = 0; i < 6; i++) begin
      rd_reg(3'(i), d); check("R11 threshold readback", d, 16'(i + 1));
    end
    wr_reg(3'd6, 16'h002A);
    rd_reg(3'd6, d); check("R11 enable readback", d, 16'h002A);
    wr_reg(3'd7, 16'hFFFF);
    rd_reg(3'd0, d); check("R11 status write ignored thr", d, 16'h0001);
    rd_reg(3'd6, d); check("R11 status write ignored en", d, 16'h002A);
    for (int i = 0; i < 7; i++) wr_reg(3'(i), 16'h0);
  endtask

  task automatic t_fifo();
    for (int i = 0; i < 8; i++) push_tx(16'hA0 + 16'(i));
    check("R1 full level", tx_level, 8);
    check("R3 ready low when full", tx_in_ready, 0);
    push_tx(16'hFF);
    check("R3 push when full ignored", tx_level, 8);
    for (int i = 0; i < 3; i++) begin
      check("R1 order", tx_out_data, 16'hA0 + 16'(i)); pop_tx();
    end
    check("R2 pop decrements", tx_level, 5);
    tx_in_valid = 1; tx_in_data = 16'hB0; tx_out_ready = 1; tick();
    tx_in_valid = 0; tx_out_ready = 0;
    check("R2 push+pop keeps level", tx_level, 5);
    for (int i = 4; i < 8; i++) begin
      check("R1 order", tx_out_data, 16'hA0 + 16'(i)); pop_tx();
    end
    check("R1 order after wrap", tx_out_data, 16'hB0); pop_tx();
    check("R3 valid low when empty", tx_out_valid, 0);
    pop_tx();
    check("R3 pop when empty ignored", tx_level, 0);
    push_rx(16'h55);
    check("R2 rx push increments", rx_level, 1);
    check("R1 rx data", rx_out_data, 16'h55);
    pop_rx();
    check("R2 rx pop decrements", rx_level, 0);
  endtask

  task automatic t_tx_cmp();
    wr_reg(3'd0, 16'd3); wr_reg(3'd6, 16'h0001);
    tick();
    check("R4 empty tx below threshold", dma_req, 2'b01);
    for (int i = 0; i < 5; i++) push_tx(16'(i));
    tick();
    check("R4 level 5 above threshold 3", dma_req, 2'b00);
    pop_tx(); tick();
    check("R4 level 4 above threshold 3", dma_req, 2'b00);
    pop_tx();
    check("R9 request not yet updated", dma_req, 2'b00);
    tick();
    check("R4 level equals threshold", dma_req, 2'b01);
    check("R7 irq stays low", irq, 0);
    for (int i = 0; i < 3; i++) pop_tx();
    wr_reg(3'd6, 16'h0); wr_reg(3'd0, 16'h0);
  endtask

  task automatic t_rx_cmp();
    logic [15:0] d;
    wr_reg(3'd3, 16'd5); wr_reg(3'd6, 16'h0008);
    tick();
    check("R5 empty rx below threshold", dma_req, 2'b00);
    for (int i = 0; i < 4; i++) push_rx(16'(i));
    tick();
    check("R5 level 4 below threshold 5", dma_req, 2'b00);
    push_rx(16'h4);
    check("R9 request not yet updated", dma_req, 2'b00);
    tick();
    check("R7 dma_req[1] from rx_dma2", dma_req, 2'b10);
    wr_reg(3'd6, 16'h0);
    tick();
    check("R7 disabled source masked", dma_req, 2'b00);
    rd_reg(3'd7, d);
    check("R8 status dma2 unmasked", d[2], 1);
    check("R8 status rx level field", d[11:8], 5);
    for (int i = 0; i < 5; i++) pop_rx();
    wr_reg(3'd3, 16'h0);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr_reg(3'd5, 16'd2); wr_reg(3'd6, 16'h0020);
    tick();
    check("R6 rx irq not reached", irq, 0);
    rd_reg(3'd7, d);
    check("R8 status irq from tx side", d[0], 1);
    push_tx(16'h1); tick();
    rd_reg(3'd7, d);
    check("R8 status irq clear", d[0], 0);
    check("R8 status tx level field", d[7:4], 1);
    push_rx(16'h1); push_rx(16'h2); tick();
    check("R6 rx irq at threshold", irq, 1);
    wr_reg(3'd6, 16'h0010); tick();
    check("R6 tx irq with tx level 1", irq, 0);
    pop_tx(); tick();
    check("R6 tx irq when drained", irq, 1);
    check("R6 dma lines unaffected", dma_req, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_regs();
    t_fifo();
    t_tx_cmp();
    t_rx_cmp();
    t_irq();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule